// File: doc/BRIEF.md
# Effective Address Generator

This block turns the decoded addressing fields of a memory-operand instruction into the linear offset that the load/store path uses. The front end supplies the mode and register-or-memory fields of the addressing byte, the scale, index and base fields of the optional scaled-index byte, and the index-extension bit from the register-extension prefix. The register file supplies two read values, one for the base register and one for the index register. The block also receives the raw displacement bytes, the address of the following instruction, a flag for 64-bit mode and a flag for the address-size override prefix.

The block forms base plus scaled index plus sign-extended displacement. It supports the forms with no base and no index, and instruction-relative addressing from the next instruction address. Under the 32-bit address width, the sum wraps at 32 bits and is zero-extended. One parameter selects a purely combinational path or a single output register stage, so the block can be placed in either pipeline arrangement.

Top module: `eff_addr_gen`

## Requirements
- R1: For a scaled-index form (mod 00/01/10, rm 100), the address is base + index × 2^scale + displacement. Scale code 00 multiplies by 1, 01 by 2, 10 by 4 and 11 by 8.
- R2: The displacement width comes from the mode field. With mod 01, the low 8 bits of `disp_i` are sign-extended. With mod 10, all 32 bits are sign-extended. With mod 00, no displacement is added, except in the forms of R4 and R5.
- R3: The index code is {`rex_x` when in 64-bit mode, otherwise 0, `sib_index`}. The code 4'b0100 contributes no index. The code 4'b1100 selects a real index register. Outside 64-bit mode, `rex_x` is ignored.
- R4: A scaled-index form with mod 00 and `sib_base` 101 has no base. It adds a 32-bit sign-extended displacement instead, whatever the base register value is.
- R5: The form mod 00 with rm 101 depends on the mode. In 64-bit mode it gives `next_ip` + sign-extended disp32, with `ea_rip`=1. Outside 64-bit mode it gives the absolute disp32, with `ea_rip`=0 and no base.
- R6: The address width is 32 bits when `mode64`=0 or `addr_ovr`=1. In that case the sum is taken modulo 2^32 and zero-extended. Otherwise the sum wraps modulo 2^64.
- R7: A register-direct operand (mod 11) gives `ea_valid`=0, `ea`=0 and `ea_rip`=0.
- R8: When `in_valid`=0, all outputs are zero. With REG_OUT=1, the outputs appear one clock after the inputs. With REG_OUT=0, they appear in the same cycle.
- R9: While `rst_n` is low, the registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when REG_OUT=1) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| mode64 | input | 1 | Core runs in 64-bit mode |
| addr_ovr | input | 1 | Address-size override prefix present |
| modrm_mod | input | 2 | Mode field of the addressing byte |
| modrm_rm | input | 3 | Register-or-memory field |
| sib_scale | input | 2 | Scale code |
| sib_index | input | 3 | Index register field (low bits) |
| sib_base | input | 3 | Base register field (low bits) |
| rex_x | input | 1 | Index extension bit |
| base_val | input | ADDR_W | Base register read value |
| index_val | input | ADDR_W | Index register read value |
| disp_i | input | 32 | Raw displacement, right-aligned |
| next_ip | input | ADDR_W | Address of the following instruction |
| ea_valid | output | 1 | A memory address is present |
| ea | output | ADDR_W | Effective address |
| ea_rip | output | 1 | Address was instruction-relative |

## Verification
The bench builds two copies of the block side by side with the default widths (64-bit address, 32-bit narrow width). One copy uses REG_OUT=1 and the other uses REG_OUT=0, so every vector checks both the same-cycle and the one-cycle-late result against one model. Full 64-bit widths make the wrap at 2^64, the truncation at 2^32 and sign extension into the upper word observable. Random vectors biased toward the scaled-index and rm-101 encodings mix with directed cases for the suppressed index, the missing base and the two meanings of the rm-101 form.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [1:0] {
        DK_NONE = 2'd0,
        DK_8    = 2'd1,
        DK_32   = 2'd2
    } disp_kind_e;

    typedef struct packed {
        logic       mem;
        logic       rip;
        logic       base_en;
        logic       index_en;
        disp_kind_e dkind;
    } eag_ctrl_t;

    localparam logic [1:0] MOD_REG      = 2'b11;
    localparam logic [2:0] RM_SIB       = 3'b100;
    localparam logic [2:0] RM_NOBASE    = 3'b101;
    localparam logic [3:0] IDX_NONE     = 4'b0100;

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic       mode64,
    input  logic [1:0] modrm_mod,
    input  logic [2:0] modrm_rm,
    input  logic [2:0] sib_index,
    input  logic [2:0] sib_base,
    input  logic       rex_x,
    output eag_ctrl_t  ctrl_o
);

    logic       is_sib;
    logic       rm101_form;
    logic       sib_nobase;
    logic [3:0] idx_code;

    always_comb begin
        ctrl_o     = '0;
        is_sib     = (modrm_mod != MOD_REG) && (modrm_rm == RM_SIB);
        rm101_form = (modrm_mod == 2'b00) && (modrm_rm == RM_NOBASE);
        sib_nobase = is_sib && (modrm_mod == 2'b00) && (sib_base == RM_NOBASE);
        idx_code   = {rex_x & mode64, sib_index};

        ctrl_o.mem      = (modrm_mod != MOD_REG);
        ctrl_o.rip      = rm101_form && mode64;
        ctrl_o.base_en  = ctrl_o.mem && !rm101_form && !sib_nobase;
        ctrl_o.index_en = is_sib && (idx_code != IDX_NONE);

        unique case (modrm_mod)
            2'b01:   ctrl_o.dkind = DK_8;
            2'b10:   ctrl_o.dkind = DK_32;
            2'b00:   ctrl_o.dkind = (rm101_form || sib_nobase) ? DK_32 : DK_NONE;
            default: ctrl_o.dkind = DK_NONE;
        endcase

        // R5
        rip_base_excl_chk: assert (!(ctrl_o.rip && ctrl_o.base_en));
        // R3
        idx_none_chk: assert (!(ctrl_o.index_en && (idx_code == IDX_NONE)));
        // R7
        reg_form_chk: assert (ctrl_o.mem || (!ctrl_o.base_en && !ctrl_o.index_en && !ctrl_o.rip));
    end

endmodule

// File: rtl/eag_disp_ext.sv
module eag_disp_ext
    import eag_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [31:0]       disp_i,
    input  disp_kind_e        dkind,
    output logic [ADDR_W-1:0] disp_o
);

    always_comb begin
        unique case (dkind)
            DK_8:    disp_o = {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]};
            DK_32:   disp_o = {{(ADDR_W-32){disp_i[31]}}, disp_i};
            default: disp_o = '0;
        endcase
        // R2
        disp8_sext_chk: assert ((dkind != DK_8) || (disp_o[ADDR_W-1:7] == '0) || (disp_o[ADDR_W-1:7] == '1));
    end

endmodule

// File: rtl/eag_sum.sv
module eag_sum
    import eag_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input  eag_ctrl_t         ctrl,
    input  logic              narrow,
    input  logic [1:0]        sib_scale,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [ADDR_W-1:0] disp_ext,
    output logic [ADDR_W-1:0] sum_o
);

    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] total;

    always_comb begin
        base_term  = ctrl.rip ? next_ip : (ctrl.base_en ? base_val : '0);
        index_term = ctrl.index_en ? (index_val << sib_scale) : '0;
        total      = base_term + index_term + disp_ext;
    end

    generate
        if (ADDR_W > NARROW_W) begin : g_trunc
            assign sum_o = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, total[NARROW_W-1:0]} : total;
        end else begin : g_full
            logic unused_narrow;
            assign unused_narrow = narrow;
            assign sum_o = total;
        end
    endgenerate

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode64,
    input  logic              addr_ovr,
    input  logic [1:0]        modrm_mod,
    input  logic [2:0]        modrm_rm,
    input  logic [1:0]        sib_scale,
    input  logic [2:0]        sib_index,
    input  logic [2:0]        sib_base,
    input  logic              rex_x,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [31:0]       disp_i,
    input  logic [ADDR_W-1:0] next_ip,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_rip
);

    typedef struct packed {
        logic              valid;
        logic              rip;
        logic              narrow;
        logic [ADDR_W-1:0] ea;
    } stage_t;

    eag_ctrl_t         ctrl;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sum;
    logic              narrow;
    stage_t            stage_d;
    stage_t            stage_o;

    assign narrow = !mode64 || addr_ovr;

    eag_decode u_decode (
        .mode64    (mode64),
        .modrm_mod (modrm_mod),
        .modrm_rm  (modrm_rm),
        .sib_index (sib_index),
        .sib_base  (sib_base),
        .rex_x     (rex_x),
        .ctrl_o    (ctrl)
    );

    eag_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
        .disp_i (disp_i),
        .dkind  (ctrl.dkind),
        .disp_o (disp_ext)
    );

    eag_sum #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_sum (
        .ctrl      (ctrl),
        .narrow    (narrow),
        .sib_scale (sib_scale),
        .base_val  (base_val),
        .index_val (index_val),
        .next_ip   (next_ip),
        .disp_ext  (disp_ext),
        .sum_o     (sum)
    );

    always_comb begin
        stage_d = '0;
        if (in_valid && ctrl.mem) begin
            stage_d.valid  = 1'b1;
            stage_d.rip    = ctrl.rip;
            stage_d.narrow = narrow;
            stage_d.ea     = sum;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            stage_t stage_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign stage_o = stage_q;

            // R8
            valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ea_valid == $past(in_valid && (modrm_mod != MOD_REG)));
            // R5
            rip_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ea_rip |-> ea_valid && !$past(!mode64));
            // R7
            reg_form_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (modrm_mod == MOD_REG)) |=> (!ea_valid && (ea == '0)));
            if (ADDR_W > NARROW_W) begin : g_nchk
                // R6
                narrow_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (stage_q.valid && stage_q.narrow) |-> (stage_q.ea[ADDR_W-1:NARROW_W] == '0));
            end
        end else begin : g_comb
            assign stage_o = stage_d;
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;

            always_comb begin
                // R8
                comb_idle_chk: assert (in_valid || (!ea_valid && !ea_rip));
            end
        end
    endgenerate

    assign ea_valid = stage_o.valid;
    assign ea       = stage_o.ea;
    assign ea_rip   = stage_o.rip;

endmodule

// File: tb/eff_addr_gen_tb_top.sv
`timescale 1ns/1ps
module eff_addr_gen_tb_top;

    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          mode64 = 1'b0;
    logic          addr_ovr = 1'b0;
    logic [1:0]    modrm_mod = 2'b11;
    logic [2:0]    modrm_rm = '0;
    logic [1:0]    sib_scale = '0;
    logic [2:0]    sib_index = '0;
    logic [2:0]    sib_base = '0;
    logic          rex_x = 1'b0;
    logic [AW-1:0] base_val = '0;
    logic [AW-1:0] index_val = '0;
    logic [31:0]   disp_i = '0;
    logic [AW-1:0] next_ip = '0;

    logic          r_valid, c_valid, r_rip, c_rip;
    logic [AW-1:0] r_ea, c_ea;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eff_addr_gen #(.ADDR_W(AW), .NARROW_W(32), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64), .addr_ovr(addr_ovr),
        .modrm_mod(modrm_mod), .modrm_rm(modrm_rm), .sib_scale(sib_scale), .sib_index(sib_index),
        .sib_base(sib_base), .rex_x(rex_x), .base_val(base_val), .index_val(index_val),
        .disp_i(disp_i), .next_ip(next_ip), .ea_valid(r_valid), .ea(r_ea), .ea_rip(r_rip));

    eff_addr_gen #(.ADDR_W(AW), .NARROW_W(32), .REG_OUT(1'b0)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64), .addr_ovr(addr_ovr),
        .modrm_mod(modrm_mod), .modrm_rm(modrm_rm), .sib_scale(sib_scale), .sib_index(sib_index),
        .sib_base(sib_base), .rex_x(rex_x), .base_val(base_val), .index_val(index_val),
        .disp_i(disp_i), .next_ip(next_ip), .ea_valid(c_valid), .ea(c_ea), .ea_rip(c_rip));

    // Reference model written from the requirements.
    function automatic void model(output bit ev, output logic [AW-1:0] eo, output bit er);
        logic [AW-1:0] d, b, x, s;
        bit sib, form101, nobase, narrow;
        ev = 1'b0; eo = '0; er = 1'b0;
        if (!in_valid || modrm_mod == 2'b11) return;
        narrow  = !mode64 || addr_ovr;
        sib     = (modrm_rm == 3'd4);
        form101 = (modrm_mod == 2'b00) && (modrm_rm == 3'd5);
        nobase  = sib && (modrm_mod == 2'b00) && (sib_base == 3'd5);
        case (modrm_mod)
            2'b01:   d = AW'($signed(disp_i[7:0]));
            2'b10:   d = AW'($signed(disp_i));
            default: d = (form101 || nobase) ? AW'($signed(disp_i)) : '0;
        endcase
        if (form101) b = mode64 ? next_ip : '0;
        else if (nobase) b = '0;
        else b = base_val;
        x = '0;
        if (sib && !({(rex_x && mode64), sib_index} == 4'b0100))
            x = index_val * (AW'(1) << sib_scale);
        s = b + x + d;
        if (narrow) s = {32'h0, s[31:0]};
        ev = 1'b1; eo = s; er = form101 && mode64;
    endfunction

    task automatic cmp(input string tag, input string which, input bit gv, input logic [AW-1:0] ge,
                       input bit gr, input bit xv, input logic [AW-1:0] xe, input bit xr);
        checks++;
        if (gv !== xv || ge !== xe || gr !== xr) begin
            fails++;
            $display("FAIL %s %s: got v=%0b ea=%h rip=%0b, expected v=%0b ea=%h rip=%0b",
                     tag, which, gv, ge, gr, xv, xe, xr);
        end
    endtask

    // Inputs already set at a negedge; check comb now, registered after next posedge.
    task automatic check_cur(input string tag);
        bit xv, xr;
        logic [AW-1:0] xe;
        #1;
        model(xv, xe, xr);
        cmp(tag, "comb", c_valid, c_ea, c_rip, xv, xe, xr);
        @(posedge clk); #1;
        cmp(tag, "reg", r_valid, r_ea, r_rip, xv, xe, xr);
    endtask

    task automatic setv(input bit m64, input bit ovr, input logic [1:0] md, input logic [2:0] rm,
                        input logic [1:0] sc, input logic [2:0] ix, input logic [2:0] bs, input bit rx,
                        input logic [AW-1:0] bv, input logic [AW-1:0] iv, input logic [31:0] dp,
                        input logic [AW-1:0] nip);
        @(negedge clk);
        in_valid = 1'b1; mode64 = m64; addr_ovr = ovr; modrm_mod = md; modrm_rm = rm;
        sib_scale = sc; sib_index = ix; sib_base = bs; rex_x = rx;
        base_val = bv; index_val = iv; disp_i = dp; next_ip = nip;
    endtask

    task automatic expect_ea(input string tag, input logic [AW-1:0] want, input bit want_rip);
        #1;
        checks++;
        if (c_ea !== want || c_rip !== want_rip || c_valid !== 1'b1) begin
            fails++;
            $display("FAIL %s directed: got ea=%h rip=%0b, expected ea=%h rip=%0b", tag, c_ea, c_rip, want, want_rip);
        end
        check_cur(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R9: registered outputs held at zero while reset is low, even with valid input
        setv(1, 0, 2'b10, 3'd0, 0, 0, 0, 0, 64'h1234, 0, 32'h10, 0);
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (r_valid !== 1'b0 || r_ea !== '0 || r_rip !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset: got v=%0b ea=%h, expected v=0 ea=0", r_valid, r_ea);
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 each scale code: base 0x1000, index 0x10, disp8 0x10
        for (int sc = 0; sc < 4; sc++) begin
            setv(1, 0, 2'b01, 3'd4, 2'(sc), 3'd3, 3'd0, 0, 64'h1000, 64'h10, 32'h10, 0);
            expect_ea("R1", 64'h1010 + (64'h10 << sc), 1'b0);
        end
        // R2 disp8 negative, disp32 negative
        setv(1, 0, 2'b01, 3'd0, 0, 0, 0, 0, 64'h1000, 0, 32'h0000_0080, 0);
        expect_ea("R2", 64'h0F80, 1'b0);
        setv(1, 0, 2'b10, 3'd0, 0, 0, 0, 0, 64'h0, 0, 32'h8000_0000, 0);
        expect_ea("R2", 64'hFFFF_FFFF_8000_0000, 1'b0);
        setv(1, 0, 2'b00, 3'd3, 0, 0, 0, 0, 64'h2000, 0, 32'hFFFF_FFFF, 0);
        expect_ea("R2", 64'h2000, 1'b0);
        // R3 index code 0100 suppressed, 1100 used, rex_x ignored outside 64-bit
        setv(1, 0, 2'b01, 3'd4, 2'd1, 3'd4, 3'd0, 0, 64'h100, 64'h7, 32'h0, 0);
        expect_ea("R3", 64'h100, 1'b0);
        setv(1, 0, 2'b01, 3'd4, 2'd1, 3'd4, 3'd0, 1, 64'h100, 64'h7, 32'h0, 0);
        expect_ea("R3", 64'h10E, 1'b0);
        setv(0, 0, 2'b01, 3'd4, 2'd1, 3'd4, 3'd0, 1, 64'h100, 64'h7, 32'h0, 0);
        expect_ea("R3", 64'h100, 1'b0);
        // R4 no-base scaled-index form
        setv(1, 0, 2'b00, 3'd4, 2'd0, 3'd1, 3'd5, 0, 64'hDEAD, 64'h5, 32'h100, 0);
        expect_ea("R4", 64'h105, 1'b0);
        // R5 instruction-relative in 64-bit mode, absolute outside
        setv(1, 0, 2'b00, 3'd5, 0, 0, 0, 0, 64'hBEEF, 0, 32'hFFFF_FFF0, 64'h4000_0000_0000_1000);
        expect_ea("R5", 64'h4000_0000_0000_0FF0, 1'b1);
        setv(0, 0, 2'b00, 3'd5, 0, 0, 0, 0, 64'hBEEF, 0, 32'h1234, 64'h9000);
        expect_ea("R5", 64'h1234, 1'b0);
        // R6 truncation under override vs 64-bit wrap
        setv(1, 1, 2'b10, 3'd0, 0, 0, 0, 0, 64'h1_0000_0000, 0, 32'h10, 0);
        expect_ea("R6", 64'h10, 1'b0);
        setv(1, 0, 2'b10, 3'd0, 0, 0, 0, 0, 64'h1_0000_0000, 0, 32'h10, 0);
        expect_ea("R6", 64'h1_0000_0010, 1'b0);
        setv(1, 0, 2'b10, 3'd0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 32'h20, 0);
        expect_ea("R6", 64'h10, 1'b0);
        setv(1, 1, 2'b00, 3'd5, 0, 0, 0, 0, 0, 0, 32'h20, 64'h7_FFFF_FFF0);
        expect_ea("R6", 64'h10, 1'b1);
        // R7 register-direct
        setv(1, 0, 2'b11, 3'd4, 0, 0, 0, 0, 64'h55, 64'h66, 32'h77, 64'h88);
        check_cur("R7");
        // R8 idle input
        setv(1, 0, 2'b10, 3'd0, 0, 0, 0, 0, 64'h55, 0, 32'h77, 0);
        in_valid = 1'b0;
        check_cur("R8");

        // Random mix, R1/R6 with all forms
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] rm;
            rm = ($urandom % 3 == 0) ? 3'd4 : (($urandom % 4 == 0) ? 3'd5 : 3'($urandom));
            setv(1'($urandom), ($urandom % 4 == 0), 2'($urandom), rm, 2'($urandom), 3'($urandom),
                 3'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                 $urandom, {$urandom, $urandom});
            in_valid = ($urandom % 10 != 0);
            check_cur("R1/R6 random");
        end

        @(negedge clk); in_valid = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule